// File: doc/BRIEF.md
# Presettable Two-Section Decade Counter

This block is a 4-bit decade counter built from two sections. A divide-by-two section owns bit 0 of the output. A divide-by-five section owns bits 3 to 1. Each section advances on the falling edge of its own count clock. A mode input selects how the two count clocks are routed inside the wrapper. In BCD mode the external count input drives the divide-by-two section, and bit 0 of the output drives the divide-by-five section. In bi-quinary mode the external count input drives the divide-by-five section, and bit 3 drives the divide-by-two section. Bit 0 then becomes a square wave at one tenth of the count rate.

Two active-low controls take precedence over counting. The first is a clear. The second is a preset that copies a 4-bit data word into the counter. Both reach the output in the same cycle they are asserted, with no edge of the system clock needed. The registers take the new value at the next system clock edge. Holding the preset low makes the block a transparent 4-bit latch. Releasing it keeps the last word until the next count edge.

The count input is sampled on the system clock `clk`. One of its falling edges is recognised at the first `clk` rising edge after `cnt_in` has been seen high and then low. The ripple from one section into the other completes within that same cycle.

Top module: `dec_counter`

## Requirements
- R1: In BCD mode (`mode_bq`=0), each recognised falling edge of `cnt_in` inverts `q[0]`.
- R2: In BCD mode, starting from 0, successive falling edges of `cnt_in` step `q` through 0,1,...,9 in 8-4-2-1 weighting and then back to 0.
- R3: In bi-quinary mode (`mode_bq`=1), starting from 0, successive falling edges of `cnt_in` step `q` through 0,2,4,6,8,1,3,5,7,9 and then back to 0. The divide-by-five value sits in `q[3:1]`, with `q[1]` as its LSB.
- R4: In bi-quinary mode, `q[0]` is high for exactly 5 of every 10 consecutive count edges.
- R5: While `clr_n` is low, `q` is 0 in the same cycle. This holds whatever `load_n`, `din` and `cnt_in` do, and the counter is still 0 once `clr_n` goes high again.
- R6: While `load_n` is low and `clr_n` is high, `q` equals `din` within the same cycle, without a `clk` edge.
- R7: Falling edges of `cnt_in` that occur while `load_n` is low do not change `q`.
- R8: After `load_n` returns high, `q` keeps the last loaded word until the next recognised falling edge of `cnt_in`.
- R9: A divide-by-five value of 5, 6 or 7 in `q[3:1]` clears its weight-4 bit on the next edge of that section's clock, giving 1, 2 or 3. That edge counts as a falling edge of `q[3]`.
- R10: A low `rst_n` at a `clk` rising edge clears the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count input |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bq | input | 1 | 0 selects BCD routing, 1 selects bi-quinary routing |
| cnt_in | input | 1 | External count clock; its falling edges advance the counter |
| clr_n | input | 1 | Active-low clear, overrides every other input |
| load_n | input | 1 | Active-low preset from `din` |
| din | input | 4 | Preset data word |
| q | output | 4 | Counter value |

## Verification
There are two kinds of collision. The first is a count edge landing in a cycle where the preset or clear is already low. The bench drops `cnt_in` in exactly such a cycle and expects `q` to stay equal to the word or to zero. The second is the clear and the preset being low together. Here `q` must be zero, and it must switch to `din` the moment the clear alone is released. A third case is a ripple that crosses both sections in one cycle, such as 9 to 0 or a recovery out of an illegal divide-by-five value. The bench checks that the final value appears right after a single count edge.

// File: rtl/dec_counter_pkg.sv
// Package: shared routing-mode type and divide-by-five next-state rule.
// Assumes the divide-by-five section is 3 bits wide with legal values 0..4.
package dec_counter_pkg;
    localparam int FIVE_W  = 3;
    localparam int TOTAL_W = FIVE_W + 1;
    localparam logic [FIVE_W-1:0] FIVE_LAST = 3'd4;

    typedef enum logic {
        ROUTE_BCD = 1'b0,
        ROUTE_BIQ = 1'b1
    } route_e;

    // Next divide-by-five value; illegal values drop their weight-4 bit.
    function automatic logic [FIVE_W-1:0] five_next(input logic [FIVE_W-1:0] s);
        if (s == FIVE_LAST)     five_next = '0;
        else if (s < FIVE_LAST) five_next = s + 1'b1;
        else                    five_next = {1'b0, s[FIVE_W-2:0]};
    endfunction
endpackage

// File: rtl/dec_edge_det.sv
// Falling-edge detector for the external count input.
// Assumes din is already synchronous to clk; a fall is a registered 1 seen with a current 0.
module dec_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic din_q;

    // Remember the previous sample of the count input.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign fall = din_q & ~din;
endmodule

// File: rtl/dec_div2.sv
// Divide-by-two section: one bit that inverts on each tick.
// Assumes tick is a one-cycle strobe; clear beats preset, preset beats tick.
module dec_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic load_n,
    input  logic pd,
    input  logic tick,
    output logic state
);
    // Hold, preset, clear or toggle the single bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= 1'b0;
        else if (!clr_n)  state <= 1'b0;
        else if (!load_n) state <= pd;
        else if (tick)    state <= ~state;
    end
endmodule

// File: rtl/dec_div5.sv
// Divide-by-five section: 3-bit binary count 0..4 with recovery from 5..7.
// Assumes tick is a one-cycle strobe; clear beats preset, preset beats tick.
module dec_div5
    import dec_counter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load_n,
    input  logic [FIVE_W-1:0] pd,
    input  logic              tick,
    output logic [FIVE_W-1:0] state
);
    // Hold, preset, clear or advance the five-state count.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= '0;
        else if (!clr_n)  state <= '0;
        else if (!load_n) state <= pd;
        else if (tick)    state <= five_next(state);
    end
endmodule

// File: rtl/dec_counter.sv
// Top: routes count ticks between the two sections per mode_bq and bypasses
// clear/preset straight to q so they act without waiting for a clk edge.
// Assumes all inputs are synchronous to clk.
module dec_counter
    import dec_counter_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_bq,
    input  logic               cnt_in,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic [TOTAL_W-1:0] din,
    output logic [TOTAL_W-1:0] q
);
    route_e            route;
    logic              ext_fall;
    logic              tick0;
    logic              tick1;
    logic              bit0;
    logic [FIVE_W-1:0] five;

    assign route = route_e'(mode_bq);

    dec_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_in),
        .fall  (ext_fall)
    );

    // Route ticks; a section's falling top bit is the other section's tick.
    always_comb begin
        if (route == ROUTE_BIQ) begin
            tick1 = ext_fall;
            tick0 = ext_fall & five[FIVE_W-1];
        end else begin
            tick0 = ext_fall;
            tick1 = ext_fall & bit0;
        end
    end

    dec_div2 u_div2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .load_n (load_n),
        .pd     (din[0]),
        .tick   (tick0),
        .state  (bit0)
    );

    dec_div5 u_div5 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .load_n (load_n),
        .pd     (din[TOTAL_W-1:1]),
        .tick   (tick1),
        .state  (five)
    );

    // Output bypass: clear, then preset, then stored count.
    always_comb begin
        if (!clr_n)       q = '0;
        else if (!load_n) q = din;
        else              q = {five, bit0};
    end
endmodule

// File: rtl/dec_counter_chk.sv
// Checker for dec_counter, bound to every instance; observes ports only.
module dec_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_bq,
    input logic       clr_n,
    input logic       load_n,
    input logic [3:0] din,
    input logic [3:0] q
);
    // R5
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n) && load_n |-> q == 4'd0);

    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_n) && clr_n && $past(clr_n) |-> q == $past(din));

    // R2
    bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bq && !$past(mode_bq) && clr_n && load_n && $past(clr_n) && $past(load_n)
        && $past(q) <= 4'd9 |-> q <= 4'd9);

    // R3
    biq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bq && $past(mode_bq) && clr_n && load_n && $past(clr_n) && $past(load_n)
        && $past(q[3:1]) <= 3'd4 |-> q[3:1] <= 3'd4);

    // R9
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && load_n && $past(clr_n) && $past(load_n) && $past(q[3:1]) > 3'd4
        |-> q[3:1] == $past(q[3:1]) || q[3:1] == {1'b0, $past(q[2:1])});
endmodule

bind dec_counter dec_counter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_bq (mode_bq),
    .clr_n   (clr_n),
    .load_n  (load_n),
    .din     (din),
    .q       (q)
);

// File: tb/tb_dec_counter.sv
module tb_dec_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_bq = 1'b0;
    logic       cnt_in = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic [3:0] q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dec_counter dut (
        .clk(clk), .rst_n(rst_n), .mode_bq(mode_bq), .cnt_in(cnt_in),
        .clr_n(clr_n), .load_n(load_n), .din(din), .q(q)
    );

    // {mode, expected q after one count edge}
    localparam logic [4:0] VEC [20] = '{
        5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h00,
        5'h12, 5'h14, 5'h16, 5'h18, 5'h11, 5'h13, 5'h15, 5'h17, 5'h19, 5'h10
    };

    task automatic check(input string req, input logic [3:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%0d expected %0d", req, q, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) cnt_in = 1'b1;
        @(negedge clk) cnt_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: q=%0d expected completion", q);
        finish_run();
    end

    initial begin
        int ones;
        logic [3:0] prev;
        repeat (3) @(negedge clk);
        check("R10 reset", 4'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: BCD then bi-quinary
        ones = 0;
        foreach (VEC[i]) begin
            mode_bq = VEC[i][4];
            prev = q;
            pulse();
            check(VEC[i][4] ? "R3 biq sequence" : "R2 bcd sequence", VEC[i][3:0]);
            if (!VEC[i][4]) check("R1 bit0 toggle", {q[3:1], ~prev[0]});
            else if (q[0]) ones++;
        end
        n_chk++;
        if (ones != 5) begin
            n_fail++;
            $display("FAIL R4 duty: high=%0d expected 5", ones);
        end

        // R6: preset is transparent, no clk edge needed
        mode_bq = 1'b0;
        @(negedge clk) begin load_n = 1'b0; din = 4'd5; end
        #1 check("R6 transparent", 4'd5);
        din = 4'd10;
        #1 check("R6 transparent follow", 4'd10);
        // R7: count edge while preset low is ignored
        pulse();
        check("R7 count ignored in load", 4'd10);
        // R8: hold after release
        @(negedge clk) load_n = 1'b1;
        din = 4'd3;
        repeat (3) @(negedge clk);
        check("R8 hold after load", 4'd10);
        pulse();
        check("R8 first count after load", 4'd11);
        // R9: illegal 5 in BCD ripple -> five section 1
        pulse();
        check("R9 recover 5 in bcd", 4'd2);
        // R9: illegal 7 in bi-quinary -> 3 and bit0 toggles
        mode_bq = 1'b1;
        @(negedge clk) begin load_n = 1'b0; din = 4'd14; end
        @(negedge clk) load_n = 1'b1;
        pulse();
        check("R9 recover 7 in biq", 4'd7);

        // R5: clear beats preset, immediate
        @(negedge clk) begin clr_n = 1'b0; load_n = 1'b0; din = 4'd9; end
        #1 check("R5 clear over load", 4'd0);
        @(negedge clk) clr_n = 1'b1;
        #1 check("R6 load after clear release", 4'd9);
        @(negedge clk) begin clr_n = 1'b0; load_n = 1'b1; end
        pulse();
        check("R5 count ignored in clear", 4'd0);
        @(negedge clk) clr_n = 1'b1;
        @(negedge clk);
        check("R5 zero after clear", 4'd0);

        // R10: synchronous reset mid-count
        pulse();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset mid-run", 4'd0);

        finish_run();
    end
endmodule